// File: doc/BRIEF.md
# Eight-Pin General-Purpose I/O Port with Output Latch

This block is a general-purpose I/O port of eight pins, controlled through three registers on a small register bus: a direction register, an output latch, and a port view that shows the levels seen on the pins. Each pin that is set as an output drives its latch bit. Its output enable is the inverse of its direction bit. Incoming pin levels go through a two-stage synchronizer before any read or bit operation uses them.

Beside plain register writes, the block accepts single-cycle bit operations that set or clear one bit of a selected register. On the latch and the direction register, a bit operation changes only the bit it names. On the port view it is a read-modify-write. The synchronized pin levels are read, one bit is changed, and all eight bits are written into the latch. An input pin that is high can therefore leave a 1 in its latch bit. Software that wants its other output bits left alone should aim bit operations at the latch.

Top module: `gpio_port`

## Requirements
- R1: After reset, every direction bit is 1, the latch is 0, and every output enable is 0.
- R2: Address 0 selects the direction register, where a bit of 1 makes that pin an input and 0 an output. For example, writing 0x10 makes pin 4 the only input, and the output enables read 0xEF on the following cycle.
- R3: A read at address 2, the port view, returns the external pin levels as they were two clock edges earlier, whatever the direction bits hold.
- R4: A write at address 1 (latch) or at address 2 (port view) stores the data in the output latch. From the following cycle, `pin_out` equals the latch.
- R5: A read at address 1 returns the latch contents and not the pin levels.
- R6: A bit operation at address 2 loads the latch with the synchronized pin levels, with bit `bit_idx` forced to `bit_set`. Pins that are inputs and read high thus set their latch bits.
- R7: A bit operation at address 1 changes only latch bit `bit_idx`, to the value of `bit_set`, and leaves the other seven bits as they were.
- R8: A bit operation at address 0 changes only direction bit `bit_idx`. When a pin turns from input to output this way, it drives its current latch bit on the following cycle.
- R9: When a register write and a bit operation arrive in the same cycle and both touch the same storage, the write wins. The latch is the storage behind addresses 1 and 2, and the direction register the storage behind address 0. When they touch different storage, both take effect.
- R10: Address 3 is unused: it reads as 0, and writes and bit operations there change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_addr | input | 2 | Register select for reads and writes: 0 direction, 1 latch, 2 port view, 3 unused |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| bit_op | input | 1 | Bit operation strobe |
| bit_addr | input | 2 | Register targeted by the bit operation, same encoding as `reg_addr` |
| bit_idx | input | 3 | Index of the bit to change |
| bit_set | input | 1 | 1 sets the bit, 0 clears it |
| pin_in | input | 8 | External pin levels, asynchronous |
| pin_out | output | 8 | Per-pin output value, taken from the latch |
| pin_oe | output | 8 | Per-pin output enable, high for output pins |

## Verification
A register write and a bit operation can land on the same cycle, and the latch is reachable from two addresses. A collision on the latch can therefore come from a write at address 1 or 2 meeting a bit operation at address 1 or 2. The bench drives a latch write and a latch bit-set in one cycle and expects the written value to stand alone. It then pairs a direction write with a latch bit-set and expects both to land. A checker property confirms that a write's data reaches the latch whenever no bit operation on the latch competes with it.

// File: rtl/gpio_port_pkg.sv
// Package: shared register select encoding for the GPIO port.
// Assumes a 2-bit select shared by the register bus and bit operations.
package gpio_port_pkg;
    localparam int SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_DIR    = 2'd0,
        SEL_LATCH  = 2'd1,
        SEL_PORT   = 2'd2,
        SEL_UNUSED = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
// Multi-stage synchronizer for asynchronous pin levels.
// Assumes each bit is independent; no bus coherence is needed.
module gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First flop captures the raw pin level
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= d_async;
                end
            end else begin : g_rest
                // Later flops let metastability settle
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
// Direction register and output latch with write and bit-operation update.
// Assumes a write beats a bit operation aimed at the same storage.
module gpio_regs
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 8,
    localparam int IDX_W = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] reg_addr,
    input  logic             reg_we,
    input  logic [WIDTH-1:0] reg_wdata,
    input  logic             bit_op,
    input  logic [SEL_W-1:0] bit_addr,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic             bit_set,
    input  logic [WIDTH-1:0] pins_sync,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] lat_q
);
    logic [WIDTH-1:0] mask;
    logic [WIDTH-1:0] dir_d;
    logic [WIDTH-1:0] lat_d;
    logic             wr_dir;
    logic             wr_lat;

    // One-hot mask of the selected bit
    assign mask = {{(WIDTH-1){1'b0}}, 1'b1} << bit_idx;

    // Decode which storage a write touches; port view aliases the latch
    assign wr_dir = reg_we && (reg_addr == SEL_DIR);
    assign wr_lat = reg_we && (reg_addr == SEL_LATCH || reg_addr == SEL_PORT);

    // Next direction value: write first, then bit operation
    always_comb begin
        dir_d = dir_q;
        if (wr_dir)
            dir_d = reg_wdata;
        else if (bit_op && bit_addr == SEL_DIR)
            dir_d = bit_set ? (dir_q | mask) : (dir_q & ~mask);
    end

    // Next latch value: write, latch-view bit op, or port-view read-modify-write
    always_comb begin
        lat_d = lat_q;
        if (wr_lat)
            lat_d = reg_wdata;
        else if (bit_op && bit_addr == SEL_LATCH)
            lat_d = bit_set ? (lat_q | mask) : (lat_q & ~mask);
        else if (bit_op && bit_addr == SEL_PORT)
            lat_d = bit_set ? (pins_sync | mask) : (pins_sync & ~mask);
    end

    // Register state; reset makes all pins inputs with a cleared latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '1;
            lat_q <= '0;
        end else begin
            dir_q <= dir_d;
            lat_q <= lat_d;
        end
    end
endmodule

// File: rtl/gpio_rdmux.sv
// Read-data selector for the three register views.
// Assumes the unused select reads as zero.
module gpio_rdmux
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [SEL_W-1:0] rd_addr,
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] lat_q,
    input  logic [WIDTH-1:0] pins_sync,
    output logic [WIDTH-1:0] rd_data
);
    // Pick the view named by the address
    always_comb begin
        case (rd_addr)
            SEL_DIR:   rd_data = dir_q;
            SEL_LATCH: rd_data = lat_q;
            SEL_PORT:  rd_data = pins_sync;
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/gpio_port.sv
// Top of the GPIO port: synchronizer, register state, read mux, pin drivers.
// Assumes pin_in is asynchronous and reg_rdata is used combinationally.
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2,
    localparam int IDX_W      = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       reg_addr,
    input  logic             reg_we,
    input  logic [WIDTH-1:0] reg_wdata,
    output logic [WIDTH-1:0] reg_rdata,
    input  logic             bit_op,
    input  logic [1:0]       bit_addr,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic             bit_set,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe
);
    logic [WIDTH-1:0] pins_sync;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] lat_q;

    gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pin_in),
        .q_sync  (pins_sync)
    );

    gpio_regs #(.WIDTH(WIDTH)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .bit_op    (bit_op),
        .bit_addr  (bit_addr),
        .bit_idx   (bit_idx),
        .bit_set   (bit_set),
        .pins_sync (pins_sync),
        .dir_q     (dir_q),
        .lat_q     (lat_q)
    );

    gpio_rdmux #(.WIDTH(WIDTH)) u_rdmux (
        .rd_addr   (reg_addr),
        .dir_q     (dir_q),
        .lat_q     (lat_q),
        .pins_sync (pins_sync),
        .rd_data   (reg_rdata)
    );

    generate
        for (genvar p = 0; p < WIDTH; p++) begin : g_pin
            // Per-pin driver: latch value out, enable when direction is 0
            assign pin_out[p] = lat_q[p];
            assign pin_oe[p]  = ~dir_q[p];
        end
    endgenerate
endmodule

// File: rtl/gpio_port_checker.sv
// Property checker for gpio_port, attached by bind; observes ports only.
// Assumes the default two-stage synchronizer.
module gpio_port_checker #(
    parameter int WIDTH = 8,
    localparam int IDX_W = $clog2(WIDTH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       reg_addr,
    input logic             reg_we,
    input logic [WIDTH-1:0] reg_wdata,
    input logic [WIDTH-1:0] reg_rdata,
    input logic             bit_op,
    input logic [1:0]       bit_addr,
    input logic [IDX_W-1:0] bit_idx,
    input logic             bit_set,
    input logic [WIDTH-1:0] pin_in,
    input logic [WIDTH-1:0] pin_out,
    input logic [WIDTH-1:0] pin_oe
);
    logic [1:0] up_cnt;
    logic       lat_wr;
    logic       lat_bop;

    // Count cycles since reset, saturating, to gate the synchronizer check
    always_ff @(posedge clk) begin
        if (!rst_n)             up_cnt <= '0;
        else if (up_cnt != 2'd3) up_cnt <= up_cnt + 2'd1;
    end

    assign lat_wr  = reg_we && (reg_addr == 2'd1 || reg_addr == 2'd2);
    assign lat_bop = bit_op && (bit_addr == 2'd1 || bit_addr == 2'd2);

    p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 2'd0) |=> (pin_oe == ~$past(reg_wdata)));

    p_port_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (up_cnt >= 2'd2 && reg_addr == 2'd2) |-> (reg_rdata == $past(pin_in, 2)));

    p_latch_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lat_wr |=> (pin_out == $past(reg_wdata)));

    p_latch_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 2'd1) |-> (reg_rdata == pin_out));

    p_latch_bit_others_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_op && bit_addr == 2'd1 && !lat_wr) |=>
        (((pin_out ^ $past(pin_out)) & ~({{(WIDTH-1){1'b0}}, 1'b1} << $past(bit_idx))) == '0));

    p_latch_bit_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_op && bit_addr == 2'd1 && !lat_wr) |=> (pin_out[$past(bit_idx)] == $past(bit_set)));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!lat_wr && !lat_bop) |=> $stable(pin_out));

    p_unused_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 2'd3) |-> (reg_rdata == '0));
endmodule

bind gpio_port gpio_port_checker #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .bit_op    (bit_op),
    .bit_addr  (bit_addr),
    .bit_idx   (bit_idx),
    .bit_set   (bit_set),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
);

// File: tb/gpio_port_bench.sv
`timescale 1ns/1ps
// Directed bench for gpio_port: one task per scenario, each checking itself.
module gpio_port_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = '0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       bit_op = 1'b0;
    logic [1:0] bit_addr = '0;
    logic [2:0] bit_idx = '0;
    logic       bit_set = 1'b0;
    logic [7:0] pin_in = '0;
    logic [7:0] pin_out;
    logic [7:0] pin_oe;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    gpio_port u_gpio_port (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bit_op(bit_op),
        .bit_addr(bit_addr), .bit_idx(bit_idx), .bit_set(bit_set),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one register write during one cycle
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_we = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    // Drive one bit operation during one cycle
    task automatic bop(input logic [1:0] a, input logic [2:0] i, input logic s);
        @(negedge clk);
        bit_op = 1'b1; bit_addr = a; bit_idx = i; bit_set = s;
        @(negedge clk);
        bit_op = 1'b0;
    endtask

    // Combinational read, sampled mid-cycle
    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic set_pins(input logic [7:0] v);
        @(negedge clk);
        pin_in = v;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd(2'd0, v); check("R1 dir", v, 8'hFF);
        rd(2'd1, v); check("R1 latch", v, 8'h00);
        check("R1 oe", pin_oe, 8'h00);
    endtask

    task automatic t_direction;
        logic [7:0] v;
        wr(2'd0, 8'h10);
        check("R2 oe after dir 0x10", pin_oe, 8'hEF);
        rd(2'd0, v); check("R2 dir read", v, 8'h10);
    endtask

    task automatic t_port_read;
        logic [7:0] v;
        @(negedge clk); pin_in = 8'h3C;
        @(negedge clk);
        rd(2'd2, v); check("R3 one edge, still old", v, 8'h00);
        @(negedge clk);
        rd(2'd2, v); check("R3 two edges, new", v, 8'h3C);
        wr(2'd0, 8'h00);
        set_pins(8'hC5);
        rd(2'd2, v); check("R3 all outputs", v, 8'hC5);
    endtask

    task automatic t_latch_write;
        logic [7:0] v;
        wr(2'd1, 8'h5A);
        check("R4 latch write drives", pin_out, 8'h5A);
        wr(2'd2, 8'hA3);
        check("R4 port write to latch", pin_out, 8'hA3);
        rd(2'd1, v); check("R5 latch read not pins", v, 8'hA3);
        rd(2'd2, v); check("R5 port read pins", v, 8'hC5);
    endtask

    task automatic t_port_rmw;
        wr(2'd0, 8'h0F);
        wr(2'd1, 8'h00);
        set_pins(8'hA0);
        bop(2'd2, 3'd0, 1'b1);
        check("R6 port set pulls in high inputs", pin_out, 8'hA1);
        set_pins(8'hFF);
        bop(2'd2, 3'd7, 1'b0);
        check("R6 port clear", pin_out, 8'h7F);
    endtask

    task automatic t_latch_bit;
        wr(2'd1, 8'h00);
        set_pins(8'hA0);
        bop(2'd1, 3'd1, 1'b1);
        check("R7 latch set only bit 1", pin_out, 8'h02);
        wr(2'd1, 8'hFF);
        bop(2'd1, 3'd6, 1'b0);
        check("R7 latch clear only bit 6", pin_out, 8'hBF);
    endtask

    task automatic t_dir_bit;
        wr(2'd0, 8'hFF);
        wr(2'd1, 8'h08);
        check("R8 input, no drive", pin_oe, 8'h00);
        bop(2'd0, 3'd3, 1'b0);
        check("R8 pin 3 enabled", pin_oe, 8'h08);
        check("R8 pin 3 drives latch", pin_out, 8'h08);
    endtask

    task automatic t_collision;
        logic [7:0] v;
        wr(2'd1, 8'h00);
        @(negedge clk);
        reg_addr = 2'd1; reg_we = 1'b1; reg_wdata = 8'h55;
        bit_op = 1'b1; bit_addr = 2'd1; bit_idx = 3'd7; bit_set = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; bit_op = 1'b0;
        check("R9 write beats latch bit op", pin_out, 8'h55);
        wr(2'd1, 8'h00);
        @(negedge clk);
        reg_addr = 2'd0; reg_we = 1'b1; reg_wdata = 8'hF0;
        bit_op = 1'b1; bit_addr = 2'd1; bit_idx = 3'd0; bit_set = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; bit_op = 1'b0;
        check("R9 both: latch", pin_out, 8'h01);
        rd(2'd0, v); check("R9 both: dir", v, 8'hF0);
    endtask

    task automatic t_unused;
        logic [7:0] v;
        wr(2'd3, 8'hFF);
        bop(2'd3, 3'd2, 1'b1);
        rd(2'd3, v); check("R10 reads zero", v, 8'h00);
        rd(2'd0, v); check("R10 dir unchanged", v, 8'hF0);
        rd(2'd1, v); check("R10 latch unchanged", v, 8'h01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_direction();
        t_port_read();
        t_latch_write();
        t_port_rmw();
        t_latch_bit();
        t_dir_bit();
        t_collision();
        t_unused();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule